// File: doc/BRIEF.md
# Reset Strap Configuration Latch

This block turns a group of board-strapped pins into static configuration. While the synchronous, active-high reset is held, it registers the strap pins on every clock and counts how many consecutive clock edges the whole strap pattern has stayed unchanged. On the first clock edge after reset is released, it latches the last value sampled during reset. From then on it ignores the pins, which are free for their normal use, and presents decoded configuration outputs. These outputs are a device number, a memory size select, a memory type select, an inter-packet-gap restart policy, and a duplex select and a 2-bit line-coding select for each network port.

At the same capture edge it judges the quality of the strap pattern. A pattern that did not stay steady long enough before release raises a setup-violation flag. A synchronous line coding chosen by some ports but not by all of them raises a serial-mix error. A memory type strap at its reserved code raises a warning. All latched outputs and flags hold their values until reset is asserted again. While reset is asserted they read zero.

Top module: `strap_cfg_latch`

## Requirements
- R1: While reset is asserted, after at least one clock edge, cfg_valid and every configuration output and flag read 0.
- R2: On the first clock edge with reset low after reset was high, the outputs take the strap values that were registered at the last clock edge with reset high, and cfg_valid becomes 1.
- R3: After capture, changes on any strap pin, including a change applied in the release cycle, have no effect on any output until reset is asserted again.
- R4: dev_num equals addr_strap[4:0].
- R5: mem_1mb equals addr_strap[5]. A value of 0 selects 2 MB and a value of 1 selects 1 MB.
- R6: ipg_idle_mode equals addr_strap[6]. A value of 0 restarts the gap timer at the end of transmit enable, and a value of 1 restarts it only when there is no transmit or receive activity.
- R7: mem_edo equals memtype_strap, where 1 selects EDO. When memtype_strap is 0 (reserved), mem_type_warn is 1, otherwise it is 0.
- R8: full_dup[i] equals duplex_strap[i], where 1 is full duplex and 0 is half duplex.
- R9: ser_mode[2i+1:2i] equals {ser_hi_strap[i], ser_lo_strap[i]}. The codes are 00 for twisted pair, 01 for fiber, 10 for AUI and 11 for synchronous.
- R10: ser_mix_err is 1 when at least one port, but not every port, has code 11.
- R11: The stability count is 0 at the first reset edge. At each later reset edge it restarts at 0 if any strap pin differs from the value registered at the previous edge, and otherwise it increments, saturating at SETUP_CYCLES. setup_viol is 1 when the count at release is below SETUP_CYCLES.
- R12: The stability count starts again from 0 at each new assertion of reset, even if the strap pattern is the same as in the previous reset period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap sampling window |
| addr_strap | input | 7 | Device number [4:0], memory size [5], gap policy [6] |
| memtype_strap | input | 1 | Memory type strap |
| duplex_strap | input | NUM_PORTS | Per-port duplex straps |
| ser_hi_strap | input | NUM_PORTS | Per-port line-coding MSB straps |
| ser_lo_strap | input | NUM_PORTS | Per-port line-coding LSB straps |
| dev_num | output | DEV_W | Latched device number |
| mem_1mb | output | 1 | Memory size select |
| ipg_idle_mode | output | 1 | Gap restart policy |
| mem_edo | output | 1 | Memory type select |
| full_dup | output | NUM_PORTS | Per-port full duplex |
| ser_mode | output | 2*NUM_PORTS | Per-port line coding, 2 bits per port |
| cfg_valid | output | 1 | Configuration latched |
| setup_viol | output | 1 | Straps not steady long enough before release |
| ser_mix_err | output | 1 | Illegal mix of synchronous and other codings |
| mem_type_warn | output | 1 | Reserved memory type code latched |

## Verification
The release edge carries two events in the same cycle: the capture of the registered pattern and a fresh change on the strap pins. The bench drives a new random pattern in the same cycle that reset drops, and it then requires the outputs to show the pattern from before release. The bench also builds capture edges where a short stability window and an illegal serial-code mix occur together, and it checks that both flags appear on that one edge with the decoded fields intact. The expected counts come from a bench model of the restart and saturation rule that walks the per-edge stimulus.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  // line coding per port, MSB from the high strap
  typedef enum logic [1:0] {
    SER_TP    = 2'b00,
    SER_FIBER = 2'b01,
    SER_AUI   = 2'b10,
    SER_SYNC  = 2'b11
  } ser_mode_e;

  // field positions inside the address strap group
  localparam int MEMSZ_POS = 0;  // offset past the device number
  localparam int IPG_POS   = 1;

  function automatic logic is_sync(input logic hi, input logic lo);
    return ser_mode_e'({hi, lo}) == SER_SYNC;
  endfunction

endpackage

// File: rtl/strap_stab_cnt.sv
module strap_stab_cnt #(
  parameter int W     = 32,
  parameter int LIMIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         first,
  input  logic [W-1:0] pins,
  output logic [W-1:0] shadow,
  output logic         stable_ok
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= pins;
      if (first || (pins != shadow)) cnt <= '0;
      else if (cnt != LIM)           cnt <= cnt + 1'b1;
    end
  end

  assign stable_ok = (cnt == LIM);

  // R11
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  // R3
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cnt) && $stable(shadow));

endmodule

// File: rtl/strap_sync_check.sv
module strap_sync_check #(
  parameter int NP = 8
) (
  input  logic [NP-1:0] ser_hi,
  input  logic [NP-1:0] ser_lo,
  output logic          mix
);
  import strap_cfg_pkg::*;

  logic [NP-1:0] sync_vec;

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign sync_vec[i] = is_sync(ser_hi[i], ser_lo[i]);
  end

  assign mix = (|sync_vec) && !(&sync_vec);

endmodule

// File: rtl/strap_decode.sv
module strap_decode #(
  parameter int NP    = 8,
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [DEV_W+1:0] addr_s,
  input  logic             memtype_s,
  input  logic [NP-1:0]    duplex_s,
  input  logic [NP-1:0]    ser_hi_s,
  input  logic [NP-1:0]    ser_lo_s,
  input  logic             stable_ok,
  output logic [DEV_W-1:0] dev_num,
  output logic             mem_1mb,
  output logic             ipg_idle_mode,
  output logic             mem_edo,
  output logic [NP-1:0]    full_dup,
  output logic [2*NP-1:0]  ser_mode,
  output logic             cfg_valid,
  output logic             setup_viol,
  output logic             ser_mix_err,
  output logic             mem_type_warn
);
  import strap_cfg_pkg::*;

  logic [2*NP-1:0] ser_pack;
  logic            mix_c;

  for (genvar i = 0; i < NP; i++) begin : g_pack
    assign ser_pack[2*i+1] = ser_hi_s[i];
    assign ser_pack[2*i]   = ser_lo_s[i];
  end

  strap_sync_check #(.NP(NP)) u_sync (
    .ser_hi (ser_hi_s),
    .ser_lo (ser_lo_s),
    .mix    (mix_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_num       <= '0;
      mem_1mb       <= 1'b0;
      ipg_idle_mode <= 1'b0;
      mem_edo       <= 1'b0;
      full_dup      <= '0;
      ser_mode      <= '0;
      cfg_valid     <= 1'b0;
      setup_viol    <= 1'b0;
      ser_mix_err   <= 1'b0;
      mem_type_warn <= 1'b0;
    end else if (capture) begin
      dev_num       <= addr_s[DEV_W-1:0];
      mem_1mb       <= addr_s[DEV_W+MEMSZ_POS];
      ipg_idle_mode <= addr_s[DEV_W+IPG_POS];
      mem_edo       <= memtype_s;
      full_dup      <= duplex_s;
      ser_mode      <= ser_pack;
      cfg_valid     <= 1'b1;
      setup_viol    <= !stable_ok;
      ser_mix_err   <= mix_c;
      mem_type_warn <= !memtype_s;
    end
  end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> cfg_valid && $stable(dev_num) && $stable(ser_mode)
                && $stable(full_dup) && $stable(setup_viol) && $stable(ser_mix_err));

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_valid) |-> $past(capture));

  // R7
  warn_pair_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (mem_type_warn != mem_edo));

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch #(
  parameter int NUM_PORTS    = 8,
  parameter int SETUP_CYCLES = 10,
  parameter int DEV_W        = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DEV_W+1:0]       addr_strap,
  input  logic                   memtype_strap,
  input  logic [NUM_PORTS-1:0]   duplex_strap,
  input  logic [NUM_PORTS-1:0]   ser_hi_strap,
  input  logic [NUM_PORTS-1:0]   ser_lo_strap,
  output logic [DEV_W-1:0]       dev_num,
  output logic                   mem_1mb,
  output logic                   ipg_idle_mode,
  output logic                   mem_edo,
  output logic [NUM_PORTS-1:0]   full_dup,
  output logic [2*NUM_PORTS-1:0] ser_mode,
  output logic                   cfg_valid,
  output logic                   setup_viol,
  output logic                   ser_mix_err,
  output logic                   mem_type_warn
);
  localparam int AW = DEV_W + 2;
  localparam int PW = AW + 1 + 3*NUM_PORTS;

  logic          rst_q;
  logic          first;
  logic          capture;
  logic          stable_ok;
  logic [PW-1:0] pins;
  logic [PW-1:0] shadow;

  always_ff @(posedge clk) rst_q <= rst;

  assign first   = rst && !rst_q;
  assign capture = !rst && rst_q;
  assign pins    = {ser_hi_strap, ser_lo_strap, duplex_strap, memtype_strap, addr_strap};

  strap_stab_cnt #(.W(PW), .LIMIT(SETUP_CYCLES)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .first     (first),
    .pins      (pins),
    .shadow    (shadow),
    .stable_ok (stable_ok)
  );

  strap_decode #(.NP(NUM_PORTS), .DEV_W(DEV_W)) u_dec (
    .clk           (clk),
    .rst           (rst),
    .capture       (capture),
    .addr_s        (shadow[AW-1:0]),
    .memtype_s     (shadow[AW]),
    .duplex_s      (shadow[AW+1 +: NUM_PORTS]),
    .ser_lo_s      (shadow[AW+1+NUM_PORTS +: NUM_PORTS]),
    .ser_hi_s      (shadow[AW+1+2*NUM_PORTS +: NUM_PORTS]),
    .stable_ok     (stable_ok),
    .dev_num       (dev_num),
    .mem_1mb       (mem_1mb),
    .ipg_idle_mode (ipg_idle_mode),
    .mem_edo       (mem_edo),
    .full_dup      (full_dup),
    .ser_mode      (ser_mode),
    .cfg_valid     (cfg_valid),
    .setup_viol    (setup_viol),
    .ser_mix_err   (ser_mix_err),
    .mem_type_warn (mem_type_warn)
  );

  // R11
  viol_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (setup_viol || ser_mix_err || mem_type_warn) |-> cfg_valid);

  // R10
  mix_code_chk: assert property (@(posedge clk) disable iff (rst)
    ser_mix_err |-> (ser_mode != '1) && (ser_mode != '0));

endmodule

// File: tb/strap_cfg_latch_test.sv
`timescale 1ns/1ps
module strap_cfg_latch_test;
  localparam int NP = 8;
  localparam int LIM = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0]  addr_strap = '0;
  logic        memtype_strap = 1'b0;
  logic [NP-1:0] duplex_strap = '0, ser_hi_strap = '0, ser_lo_strap = '0;
  logic [4:0]  dev_num;
  logic        mem_1mb, ipg_idle_mode, mem_edo, cfg_valid, setup_viol, ser_mix_err, mem_type_warn;
  logic [NP-1:0]   full_dup;
  logic [2*NP-1:0] ser_mode;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] last_val = '0;

  always #4 clk = ~clk;

  strap_cfg_latch uut (
    .clk(clk), .rst(rst), .addr_strap(addr_strap), .memtype_strap(memtype_strap),
    .duplex_strap(duplex_strap), .ser_hi_strap(ser_hi_strap), .ser_lo_strap(ser_lo_strap),
    .dev_num(dev_num), .mem_1mb(mem_1mb), .ipg_idle_mode(ipg_idle_mode), .mem_edo(mem_edo),
    .full_dup(full_dup), .ser_mode(ser_mode), .cfg_valid(cfg_valid), .setup_viol(setup_viol),
    .ser_mix_err(ser_mix_err), .mem_type_warn(mem_type_warn)
  );

  // packing of a bench strap word: [6:0] addr, [7] memtype, [15:8] duplex, [23:16] lo, [31:24] hi
  task automatic put(input logic [31:0] v);
    addr_strap    = v[6:0];
    memtype_strap = v[7];
    duplex_strap  = v[15:8];
    ser_lo_strap  = v[23:16];
    ser_hi_strap  = v[31:24];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ser(input logic [31:0] v);
    logic [15:0] e;
    for (int i = 0; i < NP; i++) begin
      e[2*i+1] = v[24+i];
      e[2*i]   = v[16+i];
    end
    return e;
  endfunction

  function automatic logic exp_mix(input logic [31:0] v);
    logic [NP-1:0] s;
    s = v[31:24] & v[23:16];
    return (|s) && !(&s);
  endfunction

  task automatic check_all(input logic [31:0] v, input logic viol);
    chk("R2 cfg_valid", 32'(cfg_valid), 32'd1);
    chk("R4 dev_num", 32'(dev_num), 32'(v[4:0]));
    chk("R5 mem_1mb", 32'(mem_1mb), 32'(v[5]));
    chk("R6 ipg_idle_mode", 32'(ipg_idle_mode), 32'(v[6]));
    chk("R7 mem_edo", 32'(mem_edo), 32'(v[7]));
    chk("R7 mem_type_warn", 32'(mem_type_warn), 32'(!v[7]));
    chk("R8 full_dup", 32'(full_dup), 32'(v[15:8]));
    chk("R9 ser_mode", 32'(ser_mode), 32'(exp_ser(v)));
    chk("R10 ser_mix_err", 32'(ser_mix_err), 32'(exp_mix(v)));
    chk("R11 setup_viol", 32'(setup_viol), 32'(viol));
  endtask

  // reset period: na edges of a, then nb edges of b; release with fresh pins in the release cycle
  task automatic run(input logic [31:0] a, input int na, input logic [31:0] b, input int nb);
    int cnt = 0;
    logic [31:0] prev = '0;
    logic [31:0] fin;
    logic viol;
    for (int k = 0; k < na + nb; k++) begin
      @(negedge clk);
      rst = 1'b1;
      fin = (k < na) ? a : b;
      put(fin);
      if (k == 0) cnt = 0;
      else if (fin != prev) cnt = 0;
      else if (cnt < LIM) cnt++;
      prev = fin;
    end
    viol = (cnt < LIM);
    @(negedge clk);
    chk("R1 cfg_valid in reset", 32'(cfg_valid), 32'd0);
    chk("R1 outputs in reset", {dev_num, full_dup, ser_mode, mem_1mb, mem_edo, ipg_idle_mode},
        32'd0);
    chk("R1 flags in reset", {setup_viol, ser_mix_err, mem_type_warn}, 32'd0);
    rst = 1'b0;
    put(~fin);                      // R3: change in the release cycle is ignored
    @(negedge clk);
    check_all(fin, viol);
    for (int j = 0; j < 3; j++) begin
      put($urandom);
      @(negedge clk);
    end
    check_all(fin, viol);           // R3: later pin activity ignored
    last_val = fin;
  endtask

  function automatic logic [31:0] mk(input int kind);
    logic [31:0] v;
    v = $urandom;
    if (kind == 0) v[31:16] = 16'hFFFF;                 // all ports synchronous
    else if (kind == 1) v[23:16] = v[23:16] & ~v[31:24]; // no port synchronous
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    // R10: all ports 11, no mix; long stable window
    run(32'hFFFF_0000 | 32'h0000_00A5, 0, 32'hFFFF_00A5, 14);
    // R11: exactly LIM+1 steady edges, count reaches LIM, no violation; R7 reserved memtype
    run(32'h0, 0, 32'h00C3_3A1F & 32'hFF3F_FF7F, LIM + 1);
    // R11: one edge short, violation
    run(32'h0, 0, 32'h1200_5C0B, LIM);
    // R11: long steady then change, counter restarts
    run(32'h0F0F_F0F0, 20, 32'h0F0F_F0F1, 5);
    // R10 with R11 same capture: single port synchronous and short window
    run(32'h0, 0, 32'h0101_3386, 4);
    // R10: every port but one synchronous
    run(32'h0, 0, 32'h7FFF_00FF, 12);
    // R12: same value as last period, short window must still violate
    v = last_val;
    run(v, 6, v, 0);
    for (int t = 0; t < 24; t++) begin
      v = mk(t % 3);
      if (t % 4 == 0) run(mk(2), 1 + ($urandom % 8), v, 1 + ($urandom % 14));
      else run(v, 0, v, 1 + ($urandom % 16));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule